// File: doc/BRIEF.md
# Stack Pointer Bound Monitor

This block guards a CPU stack against running past a programmed boundary. It compares the core's stack pointer with a limit register on every clock. When monitoring is armed and the pointer lies strictly above the limit, it sends a single-cycle interrupt request to the interrupt controller.

Software sets it up through a small register port with two locations. One is an arm register, and its only live bit is bit 7. The other is a limit register. The arm bit can be set but cannot be cleared. Once it is set, the limit register rejects all writes. The configuration therefore stays fixed until the next reset. Bit 0 of the pointer and of the limit takes no part in the check, so the comparison works on word-aligned pointers.

Top module: `sp_bound_mon`

## Requirements
- R1: After reset, address 0 reads 0x0000, address 1 reads 0xFFFE, and `irq` is 0.
- R2: Address 0 returns the arm flag in bit 7, and every other bit of the read data is 0.
- R3: A write to address 0 with bit 7 of the write data at 1 sets the arm flag on the clock edge. A write with bit 7 at 0 leaves it unchanged, so only reset clears it.
- R4: The limit register stores write data with bit 0 forced to 0, and reads of address 1 always show bit 0 as 0.
- R5: While the arm flag is 1, writes to address 1 leave the limit unchanged.
- R6: A violation exists when `sp[15:1]` is strictly greater than `limit[15:1]`. Equal upper bits are not a violation, whatever bit 0 is.
- R7: If a violation exists with the arm flag at 1 in cycle t, and none existed in cycle t-1, then `irq` is 1 for cycle t+1.
- R8: `irq` stays 0 while the arm flag is 0, for any pointer value.
- R9: `irq` never stays high for two consecutive cycles. A violation that persists gives only one pulse, and a new pulse needs the condition to clear first.
- R10: Reset is synchronous and active-high, and it also clears the violation history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 1 | Register select: 0 is the arm register, 1 is the limit register |
| wdata | input | W | Write data |
| rdata | output | W | Combinational read data for the selected register |
| sp | input | W | Stack pointer from the core |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with its default values: W = 16 and a reset limit of 0xFFFE. With these values the full 16-bit pointer range can be reached, including the ceiling just below the reset limit. Random pointers are biased to within a few counts of the live limit. This makes the equal-upper-bits case and the bit-0-only difference frequent. It also makes rises and falls of the violation condition frequent. Frequent resets re-open the write window on the limit register, so the locked and unlocked paths are both exercised many times.

// File: rtl/sp_bound_mon.sv
module sp_bound_mon #(
  parameter int          W         = 16,
  parameter int          ARM_BIT   = 7,
  parameter logic [W-1:0] LIMIT_RST = 16'hFFFE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] sp,
  output logic         irq
);
  localparam int HW = W - 1;

  logic          armed;
  logic [HW-1:0] lim_hi;
  logic          viol_q;
  logic          irq_q;

  wire viol = armed && (sp[W-1:1] > lim_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      lim_hi <= LIMIT_RST[W-1:1];
      viol_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      viol_q <= viol;
      irq_q  <= viol && !viol_q;
      if (wr_en && !addr && wdata[ARM_BIT]) armed <= 1'b1;
      if (wr_en && addr && !armed) lim_hi <= wdata[W-1:1];
    end
  end

  assign rdata = addr ? {lim_hi, 1'b0} : (W'(armed) << ARM_BIT);
  assign irq   = irq_q;
endmodule

module sp_bound_mon_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         addr,
  input logic [W-1:0] rdata,
  input logic [W-1:0] sp,
  input logic         irq,
  input logic         armed,
  input logic [W-2:0] lim_hi
);
  p_arm_sticky_r3: assert property (@(posedge clk) disable iff (rst) armed |=> armed);
  p_bit0_zero_r4: assert property (@(posedge clk) disable iff (rst) addr |-> !rdata[0]);
  p_lock_r5: assert property (@(posedge clk) disable iff (rst) armed |=> $stable(lim_hi));
  p_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(armed && (sp[W-1:1] > lim_hi)));
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst) !armed |-> !irq);
  p_single_r9: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
endmodule

bind sp_bound_mon sp_bound_mon_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rdata(rdata), .sp(sp),
  .irq(irq), .armed(armed), .lim_hi(lim_hi)
);

// File: tb/sim_sp_bound_mon.sv
`timescale 1ns/1ps
module sim_sp_bound_mon;
  localparam int W = 16;
  logic clk = 0, rst = 1, wr_en = 0, addr = 0;
  logic [W-1:0] wdata = 0, sp = 0, rdata;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic         m_arm, m_vq, m_irq;
  logic [W-1:0] m_lim;

  always #4 clk = ~clk;

  sp_bound_mon u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sp(sp), .irq(irq));

  function automatic logic [W-1:0] exp_rd(logic a);
    return a ? m_lim : (m_arm ? 16'h0080 : 16'h0000);
  endfunction

  function automatic logic exp_viol(logic [W-1:0] p);
    return m_arm && (p[W-1:1] > m_lim[W-1:1]);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic r, logic w, logic a, logic [W-1:0] d, logic [W-1:0] p);
    logic v;
    @(negedge clk);
    rst = r; wr_en = w; addr = a; wdata = d; sp = p;
    @(posedge clk);
    if (r) begin
      m_arm = 0; m_lim = 16'hFFFE; m_vq = 0; m_irq = 0;
    end else begin
      v = exp_viol(p);
      m_irq = v && !m_vq;
      m_vq = v;
      if (w && a && !m_arm) m_lim = d & 16'hFFFE;
      if (w && !a && d[7]) m_arm = 1;
    end
    #1;
    check({tag, " irq"}, W'(irq), W'(m_irq));
    check({tag, " rdata"}, rdata, exp_rd(a));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] p, d;
    void'($urandom(32'd4711));
    step("R1 reset", 1, 0, 0, 0, 0);
    step("R1 ctrl", 0, 0, 0, 0, 0);
    step("R1 limit", 0, 0, 1, 0, 0);
    step("R4 bit0", 0, 1, 1, 16'h1235, 0);
    step("R8 disabled", 0, 0, 1, 0, 16'hF000);
    step("R8 disabled", 0, 0, 0, 0, 16'hFFFF);
    step("R3 zero write", 0, 1, 0, 16'h007F, 16'hFFFF);
    step("R3 arm", 0, 1, 0, 16'h0080, 16'h1234);
    step("R2 read", 0, 0, 0, 0, 16'h1234);
    step("R6 equal", 0, 0, 0, 0, 16'h1235);
    step("R6 above", 0, 0, 0, 0, 16'h1236);
    step("R7 pulse", 0, 0, 0, 0, 16'h1236);
    step("R9 held", 0, 0, 0, 0, 16'h2000);
    step("R9 clear", 0, 0, 0, 0, 16'h0100);
    step("R9 again", 0, 0, 0, 0, 16'h8000);
    step("R9 again", 0, 0, 1, 0, 16'h8000);
    step("R5 locked", 0, 1, 1, 16'h0000, 16'h8000);
    step("R3 clear try", 0, 1, 0, 16'hFF7F, 16'h8000);
    step("R10 reset", 1, 0, 0, 0, 16'h8000);
    step("R10 after", 0, 0, 1, 0, 16'h8000);
    for (int i = 0; i < 6000; i++) begin
      case ($urandom % 4)
        0: p = $urandom;
        default: p = m_lim + W'(($urandom % 7)) - W'(3);
      endcase
      d = $urandom;
      if (($urandom % 6) != 0) d[7] = 0;
      step("R7 random", ($urandom % 250) == 0, ($urandom % 4) == 0, $urandom % 2, d, p);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule